// File: doc/BRIEF.md
# Arbiter PUF Bias Calibration Controller

This block trims the control code of a delay-adjustment stage that sits in front of a two-path arbiter physical unclonable function. Routing asymmetry skews such a function so that it answers one far more often than zero. The controller measures that skew and corrects it. On a start request it loads a mid-scale adjustment code. It then plays a batch of challenges from an internal table into the function, waiting for each answer, and tallies the answers that come back as one.

At the end of each batch the tally is compared with a tolerance window centred on half the batch size. When the tally falls inside the window, the loop stops. Otherwise a binary-search stepper moves the adjustment code toward balance and a new batch begins. The step halves each time the direction of the error reverses. The loop gives up, raising a fail flag with done, in two cases: the code would have to pass its minimum or maximum, or a set number of rounds has run out.

Top module: `puf_bias_calibrator`

## Requirements
- R1: In every round the challenges are taken from the internal table in ascending address order 0 to BATCH-1. Entry a holds the low CHAL_W bits of (a * 32'h9E3779B1) XOR 32'h5A5A5A5A. Each challenge is flagged by chal_valid, which is high for exactly one cycle.
- R2: A start seen while idle has these effects one cycle later: adj_code is 2**(ADJ_W-1), busy is 1, and done and fail are 0. The search step is loaded with 2**(ADJ_W-2).
- R3: After a challenge, the controller waits for resp_valid before it issues the next one. Each resp is counted exactly once, on its resp_valid cycle.
- R4: A round consists of BATCH challenges. The round's ones count is the number of those challenges answered with resp = 1.
- R5: If a round's ones count is within BATCH/2 +/- TOL (bounds included), the controller finishes with done = 1 and fail = 0, and adj_code keeps the code used in that round.
- R6: A count above the window raises adj_code by the current step. A count below the window lowers it by the step. The next round then starts. adj_code does not change while a round is running.
- R7: From the second evaluation onward, if the error direction differs from the previous evaluation, the step is halved before it is applied. The step never drops below 1.
- R8: adj_code saturates at 0 and at 2**ADJ_W-1 and never wraps. If the code is already at the limit the error points past, the controller finishes with done = 1 and fail = 1.
- R9: If the round numbered MAX_ITER is evaluated and its count is still outside the window, the controller finishes with done = 1 and fail = 1. adj_code then holds the code used in that round.
- R10: When the controller finishes, busy goes to 0 in the same cycle that done rises. After that, done, fail and adj_code hold until the next start.
- R11: A synchronous reset returns the controller to idle with busy, done, fail and chal_valid at 0 and adj_code at 2**(ADJ_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calibration (accepted only while idle) |
| resp | input | 1 | Response bit from the PUF |
| resp_valid | input | 1 | resp is valid this cycle |
| chal | output | CHAL_W | Challenge applied to the PUF |
| chal_valid | output | 1 | One-cycle strobe: new challenge on chal |
| adj_code | output | ADJ_W | Control code for the delay-adjustment stage |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | Calibration finished; held until next start |
| fail | output | 1 | Finished without reaching the window |

## Verification
The checker assumes the PUF answers only while a calibration is running. It also assumes that an answer never arrives in the same cycle as the challenge strobe: at least one cycle of settling separates them. The bench's PUF model meets both assumptions. It answers only after it has seen chal_valid, with a latency of one to three cycles. Around the mid-run reset it holds reset for longer than its maximum latency, so no stale answer reaches an idle controller.

// File: rtl/puf_cal_pkg.sv
package puf_cal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_ISSUE,
    ST_WAIT,
    ST_EVAL
  } cal_state_t;

  // Challenge table contents, computed rather than listed
  function automatic logic [31:0] chal_word(input int unsigned a);
    logic [31:0] av;
    av = 32'(a);
    return (av * 32'h9E3779B1) ^ 32'h5A5A5A5A;
  endfunction

endpackage

// File: rtl/puf_chal_rom.sv
module puf_chal_rom #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  import puf_cal_pkg::*;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(chal_word(i));
  end

  // Registered read so the table maps onto block RAM
  always_ff @(posedge clk) begin
    data <= mem[addr];
  end
endmodule

// File: rtl/puf_ones_tally.sv
module puf_ones_tally #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end
endmodule

// File: rtl/puf_adj_stepper.sv
module puf_adj_stepper #(
  parameter int ADJ_W = 8,
  parameter int CW    = 9,
  parameter int BATCH = 256,
  parameter int TOL   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             apply,
  input  logic [CW-1:0]    ones,
  output logic [ADJ_W-1:0] adj,
  output logic             in_win,
  output logic             want_up,
  output logic             blocked
);
  localparam int HALF = BATCH / 2;
  localparam int LO   = HALF - TOL;
  localparam int HI   = HALF + TOL;
  localparam logic [ADJ_W-1:0] ADJ_MAX = {ADJ_W{1'b1}};
  localparam logic [ADJ_W-1:0] ADJ_INIT = ADJ_W'(2 ** (ADJ_W - 1));
  localparam logic [ADJ_W-1:0] STEP0    = ADJ_W'(2 ** (ADJ_W - 2));

  logic [ADJ_W-1:0] step, step_eff, adj_next;
  logic [ADJ_W:0]   sum_up;
  logic             have_sign, prev_up, flip;

  always_comb begin
    in_win  = (int'(ones) >= LO) && (int'(ones) <= HI);
    want_up = int'(ones) > HALF;
    blocked = want_up ? (adj == ADJ_MAX) : (adj == '0);
    flip    = have_sign && (want_up != prev_up);
    if (flip) step_eff = (step > 1) ? (step >> 1) : ADJ_W'(1);
    else      step_eff = step;
    sum_up  = {1'b0, adj} + {1'b0, step_eff};
    if (want_up)
      adj_next = (sum_up > {1'b0, ADJ_MAX}) ? ADJ_MAX : sum_up[ADJ_W-1:0];
    else
      adj_next = (adj >= step_eff) ? (adj - step_eff) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || load) begin
      adj       <= ADJ_INIT;
      step      <= STEP0;
      have_sign <= 1'b0;
      prev_up   <= 1'b0;
    end else if (apply) begin
      adj       <= adj_next;
      step      <= step_eff;
      have_sign <= 1'b1;
      prev_up   <= want_up;
    end
  end
endmodule

// File: rtl/puf_bias_calibrator.sv
module puf_bias_calibrator #(
  parameter int CHAL_W   = 32,
  parameter int ADJ_W    = 8,
  parameter int BATCH    = 256,
  parameter int TOL      = 8,
  parameter int MAX_ITER = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              resp,
  input  logic              resp_valid,
  output logic [CHAL_W-1:0] chal,
  output logic              chal_valid,
  output logic [ADJ_W-1:0]  adj_code,
  output logic              busy,
  output logic              done,
  output logic              fail
);
  import puf_cal_pkg::*;

  localparam int AW = (BATCH > 1) ? $clog2(BATCH) : 1;
  localparam int CW = $clog2(BATCH + 1);
  localparam int IW = $clog2(MAX_ITER + 1);
  localparam logic [AW-1:0] LAST_ADDR = AW'(BATCH - 1);
  localparam logic [IW-1:0] LAST_ITER = IW'(MAX_ITER - 1);

  cal_state_t        state;
  logic [AW-1:0]     addr;
  logic [IW-1:0]     iter;
  logic [CHAL_W-1:0] rom_q;
  logic [CW-1:0]     ones;
  logic              in_win, want_up, blocked;
  logic              launch, finish_now, tally_clr, tally_inc, step_apply;

  always_comb begin
    launch     = (state == ST_IDLE) && start;
    finish_now = in_win || blocked || (iter == LAST_ITER);
    tally_clr  = launch || ((state == ST_EVAL) && !finish_now);
    tally_inc  = (state == ST_WAIT) && resp_valid && resp;
    step_apply = (state == ST_EVAL) && !finish_now;
  end

  puf_chal_rom #(.DEPTH(BATCH), .AW(AW), .DW(CHAL_W)) u_rom (
    .clk  (clk),
    .addr (addr),
    .data (rom_q)
  );

  puf_ones_tally #(.CW(CW)) u_tally (
    .clk   (clk),
    .rst   (rst),
    .clr   (tally_clr),
    .inc   (tally_inc),
    .count (ones)
  );

  puf_adj_stepper #(.ADJ_W(ADJ_W), .CW(CW), .BATCH(BATCH), .TOL(TOL)) u_step (
    .clk     (clk),
    .rst     (rst),
    .load    (launch),
    .apply   (step_apply),
    .ones    (ones),
    .adj     (adj_code),
    .in_win  (in_win),
    .want_up (want_up),
    .blocked (blocked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      addr       <= '0;
      iter       <= '0;
      chal       <= '0;
      chal_valid <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      fail       <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          chal_valid <= 1'b0;
          if (start) begin
            done  <= 1'b0;
            fail  <= 1'b0;
            busy  <= 1'b1;
            addr  <= '0;
            iter  <= '0;
            state <= ST_FETCH;
          end
        end
        ST_FETCH: state <= ST_ISSUE;
        ST_ISSUE: begin
          chal       <= rom_q;
          chal_valid <= 1'b1;
          state      <= ST_WAIT;
        end
        ST_WAIT: begin
          chal_valid <= 1'b0;
          if (resp_valid) begin
            if (addr == LAST_ADDR) begin
              state <= ST_EVAL;
            end else begin
              addr  <= addr + 1'b1;
              state <= ST_FETCH;
            end
          end
        end
        ST_EVAL: begin
          if (finish_now) begin
            done  <= 1'b1;
            fail  <= !in_win;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            iter  <= iter + 1'b1;
            addr  <= '0;
            state <= ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/puf_cal_checker.sv
module puf_cal_checker #(
  parameter int ADJ_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             resp_valid,
  input logic             chal_valid,
  input logic [ADJ_W-1:0] adj_code,
  input logic             busy,
  input logic             done,
  input logic             fail
);
  localparam logic [ADJ_W-1:0] INIT = ADJ_W'(2 ** (ADJ_W - 1));

  AST_CHAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    chal_valid |=> !chal_valid); // R1
  AST_CHAL_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    chal_valid |-> busy); // R1
  AST_START_LOADS_INIT: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !done && !fail && adj_code == INIT)); // R2
  AST_RESP_EXPECTED: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (busy && !chal_valid)); // R3
  AST_CODE_STILL_IN_ROUND: assert property (@(posedge clk) disable iff (rst)
    chal_valid |-> $stable(adj_code)); // R6
  AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    fail |-> done); // R8
  AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> !busy); // R10
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(adj_code) && $stable(fail))); // R10
endmodule

bind puf_bias_calibrator puf_cal_checker #(.ADJ_W(ADJ_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .resp_valid (resp_valid),
  .chal_valid (chal_valid),
  .adj_code   (adj_code),
  .busy       (busy),
  .done       (done),
  .fail       (fail)
);

// File: tb/puf_bias_calibrator_test.sv
`timescale 1ns/1ps
module puf_bias_calibrator_test;
  localparam int CHAL_W = 16, ADJ_W = 6, BATCH = 64, TOL = 2, MAX_ITER = 8;
  localparam int HALF = BATCH / 2, AMAX = 2 ** ADJ_W - 1, AINIT = 2 ** (ADJ_W - 1);

  logic clk = 0, rst = 1, start = 0, resp = 0, resp_valid = 0;
  logic [CHAL_W-1:0] chal;
  logic chal_valid, busy, done, fail;
  logic [ADJ_W-1:0] adj_code;

  int checks = 0, fails = 0;
  int m_center = 32, m_slope = 1, m_ofs = 0, m_lat = 1;
  int seen = 0, bad_words = 0, first_adj = -1;
  bit finished = 0;

  always #2.5 clk = ~clk;

  puf_bias_calibrator #(.CHAL_W(CHAL_W), .ADJ_W(ADJ_W), .BATCH(BATCH),
    .TOL(TOL), .MAX_ITER(MAX_ITER)) uut (
    .clk(clk), .rst(rst), .start(start), .resp(resp), .resp_valid(resp_valid),
    .chal(chal), .chal_valid(chal_valid), .adj_code(adj_code),
    .busy(busy), .done(done), .fail(fail));

  function automatic int model_ones(int a);
    int v;
    v = HALF + m_ofs + (m_center - a) * m_slope;
    if (v < 0) v = 0;
    if (v > BATCH) v = BATCH;
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // PUF model: answers each challenge after m_lat cycles
  initial begin
    forever begin
      @(negedge clk);
      if (chal_valid && !rst) begin
        int idx;
        logic [31:0] w;
        idx = seen % BATCH;
        w = (32'(idx) * 32'h9E3779B1) ^ 32'h5A5A5A5A;
        if (chal != w[CHAL_W-1:0]) bad_words++;
        if (seen == 0) first_adj = int'(adj_code);
        seen++;
        resp = (((idx * 37) % BATCH) < model_ones(int'(adj_code)));
        repeat (m_lat - 1) @(negedge clk);
        @(negedge clk);
        resp_valid = 1;
        @(negedge clk);
        resp_valid = 0;
      end
    end
  end

  task automatic predict(output int e_adj, output int e_fail, output int e_rounds);
    int a, st, it, o;
    bit have, prev, up;
    a = AINIT; st = 2 ** (ADJ_W - 2); have = 0; prev = 0; it = 0;
    e_rounds = 0;
    forever begin
      o = model_ones(a);
      e_rounds++;
      if (o >= HALF - TOL && o <= HALF + TOL) begin e_fail = 0; break; end
      up = (o > HALF);
      if ((up && a == AMAX) || (!up && a == 0)) begin e_fail = 1; break; end
      if (it == MAX_ITER - 1) begin e_fail = 1; break; end
      if (have && up != prev) st = (st > 1) ? st / 2 : 1;
      have = 1; prev = up;
      a = up ? ((a + st > AMAX) ? AMAX : a + st) : ((a < st) ? 0 : a - st);
      it++;
    end
    e_adj = a;
  endtask

  task automatic run_case(int c, int s, int o, int lat, string tag);
    int e_adj, e_fail, e_rounds, t;
    m_center = c; m_slope = s; m_ofs = o; m_lat = lat;
    predict(e_adj, e_fail, e_rounds);
    seen = 0; bad_words = 0; first_adj = -1;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check("R2 done cleared", int'(done), 0);
    check("R2 busy", int'(busy), 1);
    check("R2 initial code", int'(adj_code), AINIT);
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    if (!done) begin
      fails++; checks++;
      $display("FAIL %s watchdog: actual done 0 expected 1", tag);
      return;
    end
    check({tag, " final code"}, int'(adj_code), e_adj);
    check({tag, " fail flag"}, int'(fail), e_fail);
    check("R3/R4 challenges issued", seen, e_rounds * BATCH);
    check("R1 challenge words", bad_words, 0);
    check("R2 code at first challenge", first_adj, AINIT);
    check("R10 busy low", int'(busy), 0);
    repeat (5) @(negedge clk);
    check("R10 code held", int'(adj_code), e_adj);
    check("R10 done held", int'(done), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R11 done after reset", int'(done), 0);
    check("R11 fail after reset", int'(fail), 0);
    check("R11 busy after reset", int'(busy), 0);
    check("R11 chal_valid after reset", int'(chal_valid), 0);
    check("R11 code after reset", int'(adj_code), AINIT);

    // slope-1 sweep: converging, and saturating at both ends (R8)
    for (int c = -10; c <= 74; c += 6) begin
      if (c < 0 || c > AMAX + TOL) run_case(c, 1, 0, 1 + (c & 1), "R8 limit");
      else run_case(c, 1, 0, 1 + ((c / 6) % 3), "R5/R6/R7 converge");
    end
    // steeper slope forces direction flips (R7)
    for (int c = 5; c <= 60; c += 11) run_case(c, 3, 1, 2, "R6/R7 steep");
    // window unreachable: oscillates until the round limit (R9)
    run_case(40, 8, 4, 1, "R9 round limit");
    run_case(20, 8, -4, 3, "R9 round limit");

    // mid-run reset (R11)
    m_center = 10; m_slope = 1; m_ofs = 0; m_lat = 2;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (150) @(negedge clk);
    rst = 1;
    repeat (6) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R11 busy after mid-run reset", int'(busy), 0);
    check("R11 chal_valid after mid-run reset", int'(chal_valid), 0);
    check("R11 code after mid-run reset", int'(adj_code), AINIT);
    check("R11 done after mid-run reset", int'(done), 0);
    run_case(44, 1, 0, 1, "R5 after reset");

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule